// File: doc/BRIEF.md
# One-Shot Machine Timer Comparator

This block keeps elapsed machine time for a 32-bit hart and raises a machine timer interrupt request once the time passes a programmed deadline. A prescaler divides the core clock into time ticks. Each tick adds one to a 64-bit time count that starts from zero when the block leaves reset, which is when the hart starts running. Software reads the count one 32-bit word at a time and programs a 64-bit deadline by writing its two 32-bit halves separately.

The comparator fires only once. Writing either deadline half arms it. On an instruction step strobe, an armed comparator whose deadline is strictly below the current time latches a pending request and disarms itself. It then stays silent, even though time remains past the deadline, until software writes a deadline half again. The pending request carries interrupt flag 1, cause 7 and trap value 0, and it holds until a one-cycle acknowledge. Trap entry and priority between interrupt sources belong to the hart and are not part of this block.

Top module: `mach_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the time count, the prescaler, the deadline, the armed state and the pending request. After reset, `rd_data` reads 0 and `irq_req` is 0.
- R2: The time count starts at 0 and increases by exactly one at every PRESC-th clock edge after reset. It never changes at any other edge.
- R3: `rd_data` shows time bits 31:0 while `rd_hi`=0 and time bits 63:32 while `rd_hi`=1. The read path is combinational.
- R4: A write with `cmp_wr`=1 and `cmp_hi`=0 replaces deadline bits 31:0. A write with `cmp_hi`=1 replaces deadline bits 63:32. The other half keeps its stored value.
- R5: Any deadline write arms the comparator. Without a write since reset, the block never raises a request.
- R6: At an edge where `step_i`=1, the comparator is armed and the deadline is strictly less than the time count, `irq_req` goes to 1 after the edge. A deadline equal to the time count does not fire.
- R7: The comparison takes effect only at edges where `step_i`=1. Without a step, an overdue deadline raises nothing.
- R8: Firing disarms the comparator. No further request follows, however long time stays past the deadline, until the next deadline write.
- R9: `irq_req` stays at 1 until an edge with `irq_ack`=1. It reads 0 after that edge.
- R10: While `irq_req`=1, `irq_intr`=1, `irq_cause`=7 and `irq_tval`=0. While `irq_req`=0, `irq_intr` and `irq_cause` read 0.
- R11: A deadline write at the same edge as a would-be firing takes precedence. No request is raised at that edge, and the comparator is armed with the new value.
- R12: When a firing and `irq_ack` fall on the same edge, the firing wins and `irq_req` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Instruction step strobe; the comparison takes effect on it |
| cmp_wr | input | 1 | Deadline half write strobe |
| cmp_hi | input | 1 | Selects the half to write: 0 = bits 31:0, 1 = bits 63:32 |
| cmp_data | input | XW | Write data for the selected deadline half |
| rd_hi | input | 1 | Selects the time word to read: 0 = low, 1 = high |
| rd_data | output | XW | Selected time word |
| irq_ack | input | 1 | One-cycle acknowledge of the pending request |
| irq_req | output | 1 | Pending machine timer interrupt request |
| irq_intr | output | 1 | Interrupt flag of the request |
| irq_cause | output | XW-1 | Cause code of the request (7) |
| irq_tval | output | XW | Trap value of the request (0) |

## Verification
The bench targets the deadline that equals the time count exactly. A design that compares with "less or equal" fires one tick early. It also targets a long overdue stretch after a firing and acknowledge, where a level-style comparator would raise the request again and again. A write colliding with a firing, and an acknowledge colliding with a firing, check the two precedence rules; getting either wrong loses or invents a request. A deadline whose high half is set must hold the request off until the high half is cleared, which exposes a design that writes the wrong half or clobbers the other one.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int unsigned MTMR_CAUSE = 7;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
  parameter int PRESC = 100000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  generate
    if (PRESC <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(PRESC - 1);
      logic [PW-1:0] cnt_q;
      assign tick = (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [TW-1:0] now
);
  function automatic logic [TW-1:0] advance(input logic [TW-1:0] t);
    return t + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       now <= '0;
    else if (tick) now <= advance(now);
  end
endmodule

// File: rtl/mtmr_compare.sv
module mtmr_compare #(
  parameter int XW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              wr,
  input  mtmr_pkg::half_e   wr_half,
  input  logic [XW-1:0]     wr_data,
  input  logic [2*XW-1:0]   now,
  output logic              fire,
  output logic              armed
);
  localparam int TW = 2 * XW;

  function automatic logic past_due(input logic [TW-1:0] dl, input logic [TW-1:0] t);
    return dl < t;
  endfunction

  logic [TW-1:0] dl_q;

  assign fire = step && armed && !wr && past_due(dl_q, now);

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_q  <= '0;
      armed <= 1'b0;
    end else if (wr) begin
      if (wr_half == mtmr_pkg::HALF_HI) dl_q[TW-1:XW] <= wr_data;
      else                              dl_q[XW-1:0]  <= wr_data;
      armed <= 1'b1;
    end else if (fire) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/mach_timer.sv
module mach_timer #(
  parameter int PRESC = 100000,
  parameter int XW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          cmp_wr,
  input  logic          cmp_hi,
  input  logic [XW-1:0] cmp_data,
  input  logic          rd_hi,
  output logic [XW-1:0] rd_data,
  input  logic          irq_ack,
  output logic          irq_req,
  output logic          irq_intr,
  output logic [XW-2:0] irq_cause,
  output logic [XW-1:0] irq_tval
);
  localparam int TW = 2 * XW;

  logic          tick_w;
  logic          fire_w;
  logic          armed_w;
  logic [TW-1:0] time_w;
  logic          irq_q;

  mtmr_prescaler #(.PRESC(PRESC)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  mtmr_counter #(.TW(TW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .tick(tick_w),
    .now (time_w)
  );

  mtmr_compare #(.XW(XW)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .step   (step_i),
    .wr     (cmp_wr),
    .wr_half(mtmr_pkg::half_e'(cmp_hi)),
    .wr_data(cmp_data),
    .now    (time_w),
    .fire   (fire_w),
    .armed  (armed_w)
  );

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (fire_w)  irq_q <= 1'b1;
    else if (irq_ack) irq_q <= 1'b0;
  end

  assign rd_data   = rd_hi ? time_w[TW-1:XW] : time_w[XW-1:0];
  assign irq_req   = irq_q;
  assign irq_intr  = irq_q;
  assign irq_cause = irq_q ? (XW-1)'(mtmr_pkg::MTMR_CAUSE) : '0;
  assign irq_tval  = '0;
endmodule

// File: rtl/mach_timer_chk.sv
module mach_timer_chk #(
  parameter int XW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            tick,
  input logic            fire,
  input logic            armed,
  input logic            cmp_wr,
  input logic            irq_ack,
  input logic            irq_req,
  input logic [2*XW-1:0] now,
  input logic [XW-2:0]   irq_cause
);
  // R2
  time_adv_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> now == $past(now) + 1'b1);
  // R2
  time_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(now));
  // R5
  arm_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> armed);
  // R6
  fire_sets_req_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> irq_req);
  // R8
  fire_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !cmp_wr |=> !armed);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack && !fire |=> !irq_req);
  // R10
  cause_code_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_cause == (XW-1)'(7));
endmodule

bind mach_timer mach_timer_chk #(.XW(XW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick_w),
  .fire     (fire_w),
  .armed    (armed_w),
  .cmp_wr   (cmp_wr),
  .irq_ack  (irq_ack),
  .irq_req  (irq_req),
  .now      (time_w),
  .irq_cause(irq_cause)
);

// File: tb/mach_timer_tb.sv
module mach_timer_tb;
  localparam int P = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0, cmp_wr = 1'b0, cmp_hi = 1'b0, rd_hi = 1'b0, irq_ack = 1'b0;
  logic [31:0] cmp_data = '0;
  logic [31:0] rd_data;
  logic        irq_req, irq_intr;
  logic [30:0] irq_cause;
  logic [31:0] irq_tval;

  always #5 clk = ~clk;

  mach_timer #(.PRESC(P), .XW(32)) u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .cmp_wr(cmp_wr), .cmp_hi(cmp_hi),
    .cmp_data(cmp_data), .rd_hi(rd_hi), .rd_data(rd_data), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_intr(irq_intr), .irq_cause(irq_cause), .irq_tval(irq_tval)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R1";

  logic [63:0] m_time, m_dl;
  int          m_pre;
  bit          m_arm, m_pend;

  function automatic bit due(input logic [63:0] dl, input logic [63:0] t);
    return (t > dl);
  endfunction

  function automatic logic [31:0] word_of(input logic [63:0] t, input bit hi);
    return hi ? t[63:32] : t[31:0];
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit st, input bit wr, input bit hi, input logic [31:0] d,
                     input bit ack, input bit rh, input bit r);
    bit f;
    @(negedge clk);
    rst = r; step_i = st; cmp_wr = wr; cmp_hi = hi; cmp_data = d; irq_ack = ack; rd_hi = rh;
    @(posedge clk);
    if (r) begin
      m_time = '0; m_dl = '0; m_pre = 0; m_arm = 0; m_pend = 0;
    end else begin
      f = st && m_arm && !wr && due(m_dl, m_time);
      if (f) m_pend = 1;
      else if (ack) m_pend = 0;
      if (wr) begin
        if (hi) m_dl[63:32] = d; else m_dl[31:0] = d;
        m_arm = 1;
      end else if (f) m_arm = 0;
      if (m_pre == P - 1) begin m_pre = 0; m_time = m_time + 1; end
      else m_pre = m_pre + 1;
    end
    #2;
    chk(irq_req == m_pend, "irq_req", 64'(irq_req), 64'(m_pend));
    chk(rd_data == word_of(m_time, rh), "rd_data", 64'(rd_data), 64'(word_of(m_time, rh)));
    chk(irq_intr == m_pend, "irq_intr", 64'(irq_intr), 64'(m_pend));
    chk(irq_cause == (m_pend ? 31'd7 : 31'd0), "irq_cause", 64'(irq_cause), m_pend ? 64'd7 : 64'd0);
    chk(irq_tval == 32'd0, "irq_tval", 64'(irq_tval), 64'd0);
  endtask

  task automatic idle(input int n, input bit st);
    for (int i = 0; i < n; i++) cyc(st, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_time = '0; m_dl = '0; m_pre = 0; m_arm = 0; m_pend = 0;

    tag = "R1";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    chk(rd_data == 0 && irq_req == 0, "reset state", 64'(rd_data), 0);

    tag = "R2";
    idle(12, 0);
    chk(rd_data == 32'(12 / P), "time after 12 cycles", 64'(rd_data), 64'(12 / P));

    tag = "R5";
    idle(15, 1);
    chk(irq_req == 0, "never armed no request", 64'(irq_req), 0);

    tag = "R4";
    cyc(0, 1, 1, 32'd1, 0, 0, 0);
    cyc(0, 1, 0, 32'd0, 0, 0, 0);
    idle(20, 1);
    chk(irq_req == 0, "high half holds off", 64'(irq_req), 0);
    cyc(0, 1, 1, 32'd0, 0, 0, 0);
    tag = "R6";
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk(irq_req == 1, "low half kept, fires", 64'(irq_req), 1);

    tag = "R9";
    idle(6, 1);
    chk(irq_req == 1, "held without ack", 64'(irq_req), 1);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk(irq_req == 0, "ack clears", 64'(irq_req), 0);

    tag = "R8";
    idle(30, 1);
    chk(irq_req == 0, "no refire after disarm", 64'(irq_req), 0);

    tag = "R6";
    cyc(0, 1, 0, m_time[31:0] + 32'd2, 0, 0, 0);
    for (int i = 0; i < 4 * P; i++) begin
      if (m_time == m_dl) chk(irq_req == 0, "equal deadline silent", 64'(irq_req), 0);
      cyc(1, 0, 0, 0, 0, 0, 0);
    end
    chk(irq_req == 1, "fires once strictly past", 64'(irq_req), 1);
    cyc(0, 0, 0, 0, 1, 0, 0);

    tag = "R7";
    cyc(0, 1, 0, 32'd0, 0, 0, 0);
    idle(12, 0);
    chk(irq_req == 0, "no step no fire", 64'(irq_req), 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk(irq_req == 1, "step fires", 64'(irq_req), 1);

    tag = "R12";
    cyc(0, 1, 0, 32'd0, 0, 0, 0);
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk(irq_req == 1, "fire beats ack", 64'(irq_req), 1);
    cyc(0, 0, 0, 0, 1, 0, 0);

    tag = "R11";
    cyc(0, 1, 0, 32'd0, 0, 0, 0);
    cyc(1, 1, 0, 32'd0, 0, 0, 0);
    chk(irq_req == 0, "write beats fire", 64'(irq_req), 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk(irq_req == 1, "fires after write", 64'(irq_req), 1);

    tag = "R3";
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk(rd_data == 0, "high word", 64'(rd_data), 0);

    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      bit wr = ($urandom % 12) == 0;
      bit hi = ($urandom % 4) == 0;
      logic [31:0] d = hi ? 32'($urandom % 2 == 0 ? 0 : 1) : m_time[31:0] + 32'($urandom % 8) - 32'd3;
      cyc($urandom % 2 == 0, wr, hi, d, ($urandom % 6) == 0, $urandom % 2 == 0, 0);
    end

    tag = "R1";
    cyc(0, 1, 0, 32'd0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 1);
    chk(irq_req == 0 && rd_data == 0, "reset mid run", 64'(rd_data), 0);
    idle(10, 1);
    chk(irq_req == 0, "reset disarms", 64'(irq_req), 0);

    done = 1;
    finish_run();
  end
endmodule